// File: doc/BRIEF.md
# Conversion Channel Sequencer and Result Formatter

This block sits between the sample-clock logic of a multichannel acquisition front end and its sample FIFO. For every start-convert strobe it chooses the analog channel address. It takes the raw results of one or more parallel converters and turns each one into a right-justified 16-bit word for the FIFO write port. A 2-bit mode input selects how the address is chosen. It can stay on one fixed channel, step through channels in autosequence and wrap after a programmed top channel, follow an address written by the host, or sample every converter lane at once.

In simultaneous mode a single strobe yields one word per converter lane. These words go out on consecutive cycles, lane 0 first, so the FIFO receives NUM_CONV times as many words as strobes. Words are coded as straight binary or as two's complement sign-extended through bit 15. Pipelined converters deliver invalid results at first, so a discard option drops the results of the first strobes after acquisition starts. Words keep flowing with no host involvement while the FIFO has room. A word that meets a full FIFO is lost and raises a sticky overrun flag.

Top module: `chseq_top`

## Requirements
- R1: `mode_sel` selects the address on `chan_addr`: 0 gives `fixed_chan`, 1 gives the internal autosequence pointer, 2 gives `host_chan`, 3 (simultaneous) gives 0.
- R2: In mode 1 the pointer moves on by one on every strobe accepted while `acq_en` is high. A strobe taken at an address equal to or above `top_chan` returns it to 0. While `acq_en` is low the pointer is held at 0.
- R3: In modes 0, 1 and 2 an accepted strobe yields exactly one word, visible in the cycle after the strobe edge. The word is built from lane 0 (`smp_raw` bits ADC_BITS-1:0) and tagged on `wr_chan` with the `chan_addr` value at the strobe. The other lanes have no effect on it.
- R4: In mode 3 an accepted strobe yields NUM_CONV words on consecutive cycles, starting in the cycle after the strobe edge. Word k carries lane k (`smp_raw` bits k*ADC_BITS upward) and is tagged k.
- R5: With `bipolar` low, bits 15 down to ADC_BITS of `wr_data` are zero and the raw result sits right-justified below them.
- R6: With `bipolar` high, bit ADC_BITS-1 of the raw result is copied into every bit from ADC_BITS up to 15.
- R7: With `discard_en` high, the first DISCARD_STB strobes accepted after `acq_en` rises produce no words. In mode 3 that is DISCARD_STB*NUM_CONV words. The count starts over each time `acq_en` goes low.
- R8: A word due while `fifo_full` is high is not written (`wr_en` low) and its slot is lost. `overrun` rises one cycle later and stays high while `acq_en` remains high.
- R9: While `acq_en` is low, strobes are ignored, any burst in progress is abandoned and `overrun` is cleared.
- R10: During and after reset, `wr_en` and `overrun` are low and the autosequence pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Acquisition enable |
| mode_sel | input | 2 | Addressing mode (R1 encoding) |
| fixed_chan | input | CHW | Channel used in mode 0 |
| host_chan | input | CHW | Host-written channel used in mode 2 |
| top_chan | input | CHW | Last channel of the autosequence |
| bipolar | input | 1 | 1: sign-extended two's complement, 0: straight binary |
| discard_en | input | 1 | Enable dropping of initial pipeline results |
| smp_stb | input | 1 | Start-convert strobe carrying results |
| smp_raw | input | NUM_CONV*ADC_BITS | Raw results, lane k at bits k*ADC_BITS |
| fifo_full | input | 1 | FIFO full flag |
| chan_addr | output | CHW | Channel address for the next conversion |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 16 | Formatted word |
| wr_chan | output | CHW | Channel tag of the word |
| overrun | output | 1 | Sticky lost-word flag |

## Verification
A wrong autosequence pointer shows up on `chan_addr` and on the next word's `wr_chan` tag, one cycle after the strobe that moved it. A wrong lane index or burst length shows up within NUM_CONV cycles as a wrong tag, wrong data or a missing or extra `wr_en`. A discard counter that is off by one changes the word count over the first few strobes after enable. A lost overrun flag shows one cycle after a blocked word.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_AUTO   = 2'd1,
    MODE_HOST   = 2'd2,
    MODE_SIMUL  = 2'd3
  } seq_mode_e;

  localparam int WORD_W = 16;
endpackage

// File: rtl/chseq_rst_sync.sv
module chseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/chseq_addr_gen.sv
module chseq_addr_gen
  import chseq_pkg::*;
#(
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acq_en,
  input  seq_mode_e      mode,
  input  logic [CHW-1:0] fixed_chan,
  input  logic [CHW-1:0] host_chan,
  input  logic [CHW-1:0] top_chan,
  input  logic           step,
  output logic [CHW-1:0] chan_addr
);
  logic [CHW-1:0] ptr_q, ptr_d;

  // next pointer: wrap once the top channel has been used
  always_comb begin
    ptr_d = ptr_q;
    if (!acq_en)
      ptr_d = '0;
    else if (step && mode == MODE_AUTO)
      ptr_d = (ptr_q >= top_chan) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_comb begin
    unique case (mode)
      MODE_SINGLE: chan_addr = fixed_chan;
      MODE_AUTO:   chan_addr = ptr_q;
      MODE_HOST:   chan_addr = host_chan;
      default:     chan_addr = '0;
    endcase
  end
endmodule

// File: rtl/chseq_fmt.sv
module chseq_fmt
  import chseq_pkg::*;
#(
  parameter int ADC_BITS = 12
) (
  input  logic [ADC_BITS-1:0] raw,
  input  logic                bipolar,
  output logic [WORD_W-1:0]   word
);
  generate
    if (ADC_BITS < WORD_W) begin : g_ext
      localparam int EXT_W = WORD_W - ADC_BITS;
      logic [EXT_W-1:0] ext;
      assign ext  = bipolar ? {EXT_W{raw[ADC_BITS-1]}} : '0;
      assign word = {ext, raw};
    end else begin : g_full
      logic unused_coding;
      assign unused_coding = bipolar;
      assign word = raw[WORD_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/chseq_emit.sv
module chseq_emit #(
  parameter int NUM_CONV    = 4,
  parameter int ADC_BITS    = 12,
  parameter int CHW         = 3,
  parameter int DISCARD_STB = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acq_en,
  input  logic                         simul,
  input  logic                         discard_en,
  input  logic                         accept,
  input  logic [NUM_CONV*ADC_BITS-1:0] smp_raw,
  input  logic [CHW-1:0]               chan_addr,
  input  logic                         fifo_full,
  output logic                         emit,
  output logic [ADC_BITS-1:0]          lane,
  output logic [CHW-1:0]               tag,
  output logic                         overrun
);
  localparam int IDXW  = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1;
  localparam int DCW   = $clog2(DISCARD_STB + 1);
  localparam int RAW_W = NUM_CONV * ADC_BITS;
  localparam logic [IDXW-1:0] LAST_LANE = IDXW'(NUM_CONV - 1);
  localparam logic [DCW-1:0]  DISC_LIM  = DCW'(DISCARD_STB);

  logic            busy_q, busy_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [IDXW-1:0] lim_q;
  logic            sim_q;
  logic [CHW-1:0]  tag_q;
  logic [RAW_W-1:0] hold_q;
  logic [DCW-1:0]  disc_q, disc_d;
  logic            ovr_q, ovr_d;
  logic            dropping, load;

  assign dropping = discard_en && (disc_q < DISC_LIM);
  assign load     = acq_en && accept && !dropping;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    disc_d = disc_q;
    ovr_d  = ovr_q;
    if (!acq_en) begin
      busy_d = 1'b0;
      idx_d  = '0;
      disc_d = '0;
      ovr_d  = 1'b0;
    end else begin
      if (busy_q && fifo_full) ovr_d = 1'b1;
      if (busy_q) begin
        if (idx_q == lim_q) busy_d = 1'b0;
        else                idx_d  = idx_q + 1'b1;
      end
      if (accept && dropping) disc_d = disc_q + 1'b1;
      if (load) begin
        busy_d = 1'b1;
        idx_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      disc_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      disc_q <= disc_d;
      ovr_q  <= ovr_d;
    end
  end

  // burst descriptor, loaded only on an accepted strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      sim_q <= 1'b0;
      tag_q <= '0;
    end else if (load) begin
      lim_q <= simul ? LAST_LANE : '0;
      sim_q <= simul;
      tag_q <= chan_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (load) hold_q <= smp_raw;
  end

  assign emit    = busy_q;
  assign lane    = hold_q[int'(idx_q)*ADC_BITS +: ADC_BITS];
  assign tag     = sim_q ? CHW'(idx_q) : tag_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/chseq_top.sv
module chseq_top
  import chseq_pkg::*;
#(
  parameter int NUM_CHAN    = 8,
  parameter int NUM_CONV    = 4,
  parameter int ADC_BITS    = 12,
  parameter int DISCARD_STB = 4,
  localparam int CHW        = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int RAW_W      = NUM_CONV * ADC_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_en,
  input  logic [1:0]        mode_sel,
  input  logic [CHW-1:0]    fixed_chan,
  input  logic [CHW-1:0]    host_chan,
  input  logic [CHW-1:0]    top_chan,
  input  logic              bipolar,
  input  logic              discard_en,
  input  logic              smp_stb,
  input  logic [RAW_W-1:0]  smp_raw,
  input  logic              fifo_full,
  output logic [CHW-1:0]    chan_addr,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic [CHW-1:0]    wr_chan,
  output logic              overrun
);
  seq_mode_e           mode;
  logic                rst_n_int;
  logic                step;
  logic                emit;
  logic [ADC_BITS-1:0] lane;

  assign mode = seq_mode_e'(mode_sel);
  assign step = acq_en && smp_stb;

  chseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  chseq_addr_gen #(.CHW(CHW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .acq_en     (acq_en),
    .mode       (mode),
    .fixed_chan (fixed_chan),
    .host_chan  (host_chan),
    .top_chan   (top_chan),
    .step       (step),
    .chan_addr  (chan_addr)
  );

  chseq_emit #(
    .NUM_CONV    (NUM_CONV),
    .ADC_BITS    (ADC_BITS),
    .CHW         (CHW),
    .DISCARD_STB (DISCARD_STB)
  ) u_emit (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .acq_en     (acq_en),
    .simul      (mode == MODE_SIMUL),
    .discard_en (discard_en),
    .accept     (step),
    .smp_raw    (smp_raw),
    .chan_addr  (chan_addr),
    .fifo_full  (fifo_full),
    .emit       (emit),
    .lane       (lane),
    .tag        (wr_chan),
    .overrun    (overrun)
  );

  chseq_fmt #(.ADC_BITS(ADC_BITS)) u_fmt (
    .raw     (lane),
    .bipolar (bipolar),
    .word    (wr_data)
  );

  assign wr_en = emit && !fifo_full;
endmodule

// File: rtl/chseq_checker.sv
module chseq_checker #(
  parameter int NUM_CHAN    = 8,
  parameter int NUM_CONV    = 4,
  parameter int ADC_BITS    = 12,
  parameter int DISCARD_STB = 4,
  localparam int CHW        = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int RAW_W      = NUM_CONV * ADC_BITS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_en,
  input logic [1:0]       mode_sel,
  input logic [CHW-1:0]   fixed_chan,
  input logic [CHW-1:0]   host_chan,
  input logic [CHW-1:0]   top_chan,
  input logic             bipolar,
  input logic             discard_en,
  input logic             smp_stb,
  input logic [RAW_W-1:0] smp_raw,
  input logic             fifo_full,
  input logic [CHW-1:0]   chan_addr,
  input logic             wr_en,
  input logic [15:0]      wr_data,
  input logic [CHW-1:0]   wr_chan,
  input logic             overrun
);
  p_auto_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && mode_sel == 2'd1 && smp_stb && chan_addr >= top_chan)
    |=> (mode_sel != 2'd1 || chan_addr == '0));

  p_auto_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && mode_sel == 2'd1 && smp_stb && chan_addr < top_chan)
    |=> (mode_sel != 2'd1 || chan_addr == CHW'($past(chan_addr) + 1'b1)));

  p_lane_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && wr_en && mode_sel == 2'd3 && !smp_stb && int'(wr_chan) < NUM_CONV - 1)
    |=> (wr_chan == CHW'($past(wr_chan) + 1'b1)));

  p_unipolar_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bipolar) |-> (wr_data >> ADC_BITS) == '0);

  generate
    if (ADC_BITS < 16) begin : g_sign
      p_sign_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bipolar) |->
          ($countones(wr_data[15:ADC_BITS-1]) == 0 ||
           $countones(wr_data[15:ADC_BITS-1]) == 17 - ADC_BITS));
    end
  endgenerate

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && acq_en) |=> overrun);

  p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |=> (!wr_en && !overrun));
endmodule

bind chseq_top chseq_checker #(
  .NUM_CHAN    (NUM_CHAN),
  .NUM_CONV    (NUM_CONV),
  .ADC_BITS    (ADC_BITS),
  .DISCARD_STB (DISCARD_STB)
) u_chk (.*);

// File: tb/chseq_top_bench.sv
module chseq_top_bench;
  localparam int NUM_CHAN = 8;
  localparam int NUM_CONV = 4;
  localparam int ADC_BITS = 12;
  localparam int DISC     = 4;
  localparam int CHW      = 3;

  logic clk = 1'b0;
  logic rst_n, acq_en, bipolar, discard_en, smp_stb, fifo_full;
  logic [1:0] mode_sel;
  logic [CHW-1:0] fixed_chan, host_chan, top_chan, chan_addr, wr_chan;
  logic [NUM_CONV*ADC_BITS-1:0] smp_raw;
  logic wr_en, overrun;
  logic [15:0] wr_data;

  int checks = 0;
  int errors = 0;
  int wcount = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chseq_top #(.NUM_CHAN(NUM_CHAN), .NUM_CONV(NUM_CONV), .ADC_BITS(ADC_BITS),
              .DISCARD_STB(DISC)) u_chseq_top (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .mode_sel(mode_sel),
    .fixed_chan(fixed_chan), .host_chan(host_chan), .top_chan(top_chan),
    .bipolar(bipolar), .discard_en(discard_en), .smp_stb(smp_stb),
    .smp_raw(smp_raw), .fifo_full(fifo_full), .chan_addr(chan_addr),
    .wr_en(wr_en), .wr_data(wr_data), .wr_chan(wr_chan), .overrun(overrun));

  always @(negedge clk) if (wr_en) wcount++;

  // {bipolar, raw lane 0, expected word}
  localparam logic [28:0] FMT_VEC [8] = '{
    {1'b1, 12'h800, 16'hF800}, {1'b1, 12'h7FF, 16'h07FF},
    {1'b1, 12'hFFF, 16'hFFFF}, {1'b1, 12'h001, 16'h0001},
    {1'b0, 12'h800, 16'h0800}, {1'b0, 12'hFFF, 16'h0FFF},
    {1'b0, 12'h000, 16'h0000}, {1'b1, 12'hA5A, 16'hFA5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [NUM_CONV*ADC_BITS-1:0] raw);
    smp_raw = raw;
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] sim_exp [4];
    int base;
    rst_n = 1'b0; acq_en = 1'b0; bipolar = 1'b0; discard_en = 1'b0;
    smp_stb = 1'b0; fifo_full = 1'b0; mode_sel = 2'd1;
    fixed_chan = 3'd5; host_chan = 3'd6; top_chan = 3'd3; smp_raw = '0;
    tick(3);
    chk("R10 wr_en in reset", wr_en, 0);
    chk("R10 overrun in reset", overrun, 0);
    rst_n = 1'b1;
    tick(4);
    acq_en = 1'b1;
    tick(1);
    chk("R10 pointer after reset", chan_addr, 0);

    // R3 R5 R6: coding table in single mode, upper lanes hold noise
    mode_sel = 2'd0;
    tick(1);
    chk("R1 single address", chan_addr, 5);
    for (int i = 0; i < 8; i++) begin
      bipolar = FMT_VEC[i][28];
      strobe({12'h5A5, 12'hC3C, 12'h9F0, FMT_VEC[i][27:16]});
      chk("R3 one word per strobe", wr_en, 1);
      chk(FMT_VEC[i][28] ? "R6 sign extension" : "R5 straight binary",
          wr_data, FMT_VEC[i][15:0]);
      chk("R3 tag", wr_chan, 5);
      tick(1);
      chk("R3 single word only", wr_en, 0);
    end

    // R2 autosequence with wrap
    mode_sel = 2'd1; bipolar = 1'b0;
    tick(1);
    for (int k = 0; k < 6; k++) begin
      chk("R2 address before strobe", chan_addr, k % 4);
      strobe({36'h0, 12'(k)});
      chk("R2 tag follows sequence", wr_chan, k % 4);
      tick(1);
    end
    acq_en = 1'b0;
    tick(1);
    acq_en = 1'b1;
    chk("R2 pointer cleared by disable", chan_addr, 0);

    // R1 host and simultaneous addressing
    mode_sel = 2'd2;
    tick(1);
    chk("R1 host address", chan_addr, 6);
    strobe(48'h0);
    chk("R3 host tag", wr_chan, 6);
    tick(1);
    mode_sel = 2'd3;
    tick(1);
    chk("R1 simul address", chan_addr, 0);

    // R4 interleave of lanes
    bipolar = 1'b1;
    sim_exp[0] = 16'h07FF; sim_exp[1] = 16'hF800;
    sim_exp[2] = 16'hFFFE; sim_exp[3] = 16'h0123;
    strobe({12'h123, 12'hFFE, 12'h800, 12'h7FF});
    for (int k = 0; k < 4; k++) begin
      chk("R4 word present", wr_en, 1);
      chk("R4 lane tag", wr_chan, k);
      chk("R4 lane data", wr_data, sim_exp[k]);
      tick(1);
    end
    chk("R4 burst length", wr_en, 0);
    tick(2);

    // R7 discard of initial strobes
    acq_en = 1'b0; discard_en = 1'b1;
    tick(1);
    acq_en = 1'b1;
    tick(1);
    base = wcount;
    for (int k = 0; k < DISC; k++) begin
      strobe(48'h111_222_333_444);
      tick(4);
    end
    chk("R7 first strobes dropped", wcount - base, 0);
    strobe(48'h004_003_002_001);
    chk("R7 word after discard", wr_en, 1);
    chk("R7 first kept data", wr_data, 16'h0001);
    tick(5);
    chk("R7 kept burst size", wcount - base, NUM_CONV);
    acq_en = 1'b0;
    tick(1);
    acq_en = 1'b1;
    tick(1);
    strobe(48'h004_003_002_001);
    chk("R7 discard restarts", wr_en, 0);
    tick(5);
    discard_en = 1'b0;

    // R8 full FIFO
    mode_sel = 2'd0; bipolar = 1'b0; fifo_full = 1'b1;
    strobe(48'h00A);
    chk("R8 write blocked", wr_en, 0);
    chk("R8 overrun not yet", overrun, 0);
    tick(1);
    chk("R8 overrun set", overrun, 1);
    fifo_full = 1'b0;
    tick(2);
    chk("R8 overrun sticky", overrun, 1);
    strobe(48'h00B);
    chk("R8 writes resume", wr_en, 1);
    acq_en = 1'b0;
    tick(1);
    chk("R9 overrun cleared", overrun, 0);

    // R9 disabled acquisition
    strobe(48'h00C);
    chk("R9 strobe ignored", wr_en, 0);
    tick(1);
    chk("R9 still idle", wr_en, 0);
    acq_en = 1'b1; mode_sel = 2'd3;
    tick(1);
    strobe(48'h004_003_002_001);
    chk("R9 burst started", wr_en, 1);
    acq_en = 1'b0;
    tick(1);
    chk("R9 burst abandoned", wr_en, 0);
    tick(2);

    done = 1'b1;
    finish_run();
  end
endmodule